// File: doc/BRIEF.md
# Serial Flash Pin Front-End with Select Arming and Pause Control

This block sits between the raw pins of a serial flash slave and its internal command engine. It brings chip-select, serial clock, data-in and the pause pin into the system clock domain. From them it decides when the device is really selected, and it produces one clock-enable strobe for each valid serial-clock rising edge and each valid falling edge. It also gates the output enable of the data-out pin.

After reset the device is not selected, even if chip-select is already low. A high level followed by a low level on chip-select must be seen first. A pause (hold) is entered or left only while the serial clock is low. During a pause, strobes are masked and the output is released, so the engine keeps its bit position and the transfer picks up where it stopped. Each deselect sends a one-cycle state-reset pulse to the engine. A deselect during a pause also raises an abort pulse. When the quad-enable input is set, the pause pin is ignored.

The system clock must run at least four times faster than the serial clock.

Top module: `sflash_pin_frontend`

## Requirements
- R1: After reset, `selected` stays 0 and no `sck_rise_en` strobe appears while chip-select stays low. `selected` becomes 1 only after chip-select has been seen high and then low.
- R2: While selected and not paused, each serial-clock rising edge gives exactly one single-cycle `sck_rise_en` strobe, and `si_bit` carries the data-in level for that edge.
- R3: `standby` is 1 exactly when the device is deselected and `write_busy` is 0.
- R4: A pause can only start while the device is selected. A low pause pin while chip-select is high has no effect on `hold_active`.
- R5: A pause starts when the pause pin is low while the serial clock is low. During the pause `so_oe` is 0 and serial-clock edges give no strobes.
- R6: Bits clocked before and after a pause form one contiguous word, with nothing inserted by the clocks that toggled during the pause.
- R7: A change on the pause pin while the serial clock is high takes effect only after the next serial-clock falling edge. This holds for both entry and exit.
- R8: A deselect during a pause gives one single-cycle `abort_pulse` and one `eng_rst` pulse, and it clears the pause.
- R9: Every deselect of a selected device gives exactly one single-cycle `eng_rst` pulse. `abort_pulse` stays 0 when no pause was active. Raising chip-select on a device that was never selected gives no pulse.
- R10: With `quad_en` = 1 the pause function is off: `hold_active` stays 0 and strobes continue whatever the pause pin does.
- R11: `so_oe` follows `so_oe_req` while the device is selected and not paused, and is 0 otherwise. `sck_fall_en` gives one strobe for each serial-clock falling edge under the same conditions as R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| cs_n_pin | input | 1 | Raw chip-select pin, active low |
| sck_pin | input | 1 | Raw serial clock pin |
| si_pin | input | 1 | Raw serial data-in pin |
| hold_n_pin | input | 1 | Raw pause pin, active low |
| quad_en | input | 1 | 1 turns the pause function off |
| write_busy | input | 1 | An internal write cycle is running |
| so_oe_req | input | 1 | The engine wants to drive data-out |
| so_data | input | 1 | Data-out bit from the engine |
| selected | output | 1 | The device is selected |
| hold_active | output | 1 | A pause is active |
| sck_rise_en | output | 1 | Strobe for a valid serial-clock rising edge |
| sck_fall_en | output | 1 | Strobe for a valid serial-clock falling edge |
| si_bit | output | 1 | Synchronised data-in level |
| so_out | output | 1 | Data-out pin value |
| so_oe | output | 1 | Data-out pin output enable |
| eng_rst | output | 1 | Single-cycle engine state reset on deselect |
| abort_pulse | output | 1 | Single-cycle abort on a deselect during a pause |
| standby | output | 1 | Deselected with no write cycle running |

## Verification
The bench builds the block with `SYNC_STAGES` = 2 and `HOLD_SUPPORT` = 1, so the pause logic is present and the path from pin to strobe stays short. The serial clock runs at one eighth of the system clock. This keeps all 256 byte values within reach in a full sweep of bit capture. The same build covers pauses that split a byte, pause pin changes while the serial clock is high, deselects with and without a pause, and a chip-select held low from reset.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
   typedef struct packed {
      logic cs_n;
      logic sck;
      logic si;
      logic hold_n;
   } pin_vec_t;

   localparam int PIN_W = $bits(pin_vec_t);
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync
   import sfe_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  pin_vec_t pins_raw,
   output pin_vec_t pins_now,
   output pin_vec_t pins_prev
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sfe_sync: STAGES must be at least 2");
      end
   endgenerate

   pin_vec_t chain [STAGES];

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= '0;
               else        chain[g] <= pins_raw;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= '0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign pins_now = chain[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pins_prev <= '0;
      else        pins_prev <= pins_now;
   end
endmodule

// File: rtl/sfe_select.sv
module sfe_select (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_now,
   input  logic cs_prev,
   output logic selected,
   output logic desel_evt
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         selected <= 1'b0;
      end else begin
         if (cs_now) armed <= 1'b1;
         if (cs_now)
            selected <= 1'b0;
         else if (armed && cs_prev)
            selected <= 1'b1;
      end
   end

   assign desel_evt = selected && cs_now;
endmodule

// File: rtl/sfe_hold.sv
module sfe_hold #(
   parameter bit HOLD_SUPPORT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic selected,
   input  logic desel_evt,
   input  logic quad_en,
   input  logic sck_now,
   input  logic hold_n_now,
   output logic hold_active
);
   generate
      if (HOLD_SUPPORT) begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               hold_active <= 1'b0;
            else if (!selected || desel_evt || quad_en)
               hold_active <= 1'b0;
            else if (!sck_now)
               hold_active <= !hold_n_now;
         end
      end else begin : g_no_hold
         logic unused_hold_in;
         assign unused_hold_in = ^{clk, rst_n, selected, desel_evt, quad_en, sck_now, hold_n_now};
         assign hold_active = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/sflash_pin_frontend.sv
module sflash_pin_frontend
   import sfe_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter bit HOLD_SUPPORT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_pin,
   input  logic sck_pin,
   input  logic si_pin,
   input  logic hold_n_pin,
   input  logic quad_en,
   input  logic write_busy,
   input  logic so_oe_req,
   input  logic so_data,
   output logic selected,
   output logic hold_active,
   output logic sck_rise_en,
   output logic sck_fall_en,
   output logic si_bit,
   output logic so_out,
   output logic so_oe,
   output logic eng_rst,
   output logic abort_pulse,
   output logic standby
);
   pin_vec_t pins_raw, pins_now, pins_prev;
   logic     desel_evt;
   logic     pass_ok;

   assign pins_raw = '{cs_n: cs_n_pin, sck: sck_pin, si: si_pin, hold_n: hold_n_pin};

   sfe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .pins_raw  (pins_raw),
      .pins_now  (pins_now),
      .pins_prev (pins_prev)
   );

   sfe_select u_select (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_now    (pins_now.cs_n),
      .cs_prev   (pins_prev.cs_n),
      .selected  (selected),
      .desel_evt (desel_evt)
   );

   sfe_hold #(.HOLD_SUPPORT(HOLD_SUPPORT)) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .selected    (selected),
      .desel_evt   (desel_evt),
      .quad_en     (quad_en),
      .sck_now     (pins_now.sck),
      .hold_n_now  (pins_now.hold_n),
      .hold_active (hold_active)
   );

   assign pass_ok     = selected && !hold_active && !desel_evt;
   assign sck_rise_en = pass_ok && pins_now.sck && !pins_prev.sck;
   assign sck_fall_en = pass_ok && !pins_now.sck && pins_prev.sck;
   assign si_bit      = pins_now.si;
   assign so_out      = so_data;
   assign so_oe       = pass_ok && so_oe_req;
   assign standby     = !selected && !write_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eng_rst     <= 1'b0;
         abort_pulse <= 1'b0;
      end else begin
         eng_rst     <= desel_evt;
         abort_pulse <= desel_evt && hold_active;
      end
   end

   logic unused_prev;
   assign unused_prev = ^{pins_prev.si, pins_prev.hold_n};
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker (
   input logic clk,
   input logic rst_n,
   input logic quad_en,
   input logic write_busy,
   input logic selected,
   input logic hold_active,
   input logic sck_rise_en,
   input logic sck_fall_en,
   input logic so_oe,
   input logic eng_rst,
   input logic abort_pulse,
   input logic standby
);
   assert_no_strobe_unselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !selected |-> !sck_rise_en);
   assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sck_rise_en |=> !sck_rise_en);
   assert_selected_not_standby_R3: assert property (@(posedge clk) disable iff (!rst_n)
      selected |-> !standby);
   assert_hold_needs_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hold_active |-> selected);
   assert_hold_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hold_active |-> (!so_oe && !sck_rise_en && !sck_fall_en));
   assert_abort_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |=> !abort_pulse);
   assert_abort_after_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |-> ($past(hold_active) && !selected && eng_rst && !hold_active));
   assert_rst_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      eng_rst |=> !eng_rst);
   assert_quad_no_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(quad_en) |-> !hold_active);
   assert_standby_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      write_busy |-> !standby);
endmodule

bind sflash_pin_frontend sfe_checker u_sfe_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .quad_en     (quad_en),
   .write_busy  (write_busy),
   .selected    (selected),
   .hold_active (hold_active),
   .sck_rise_en (sck_rise_en),
   .sck_fall_en (sck_fall_en),
   .so_oe       (so_oe),
   .eng_rst     (eng_rst),
   .abort_pulse (abort_pulse),
   .standby     (standby)
);

// File: tb/sflash_pin_frontend_bench.sv
module sflash_pin_frontend_bench;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, cs_n_pin, sck_pin, si_pin, hold_n_pin, quad_en, write_busy, so_oe_req, so_data;
   logic selected, hold_active, sck_rise_en, sck_fall_en, si_bit, so_out, so_oe, eng_rst, abort_pulse, standby;

   sflash_pin_frontend #(.SYNC_STAGES(2), .HOLD_SUPPORT(1'b1)) u_sflash_pin_frontend (
      .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .sck_pin(sck_pin), .si_pin(si_pin),
      .hold_n_pin(hold_n_pin), .quad_en(quad_en), .write_busy(write_busy),
      .so_oe_req(so_oe_req), .so_data(so_data), .selected(selected), .hold_active(hold_active),
      .sck_rise_en(sck_rise_en), .sck_fall_en(sck_fall_en), .si_bit(si_bit), .so_out(so_out),
      .so_oe(so_oe), .eng_rst(eng_rst), .abort_pulse(abort_pulse), .standby(standby)
   );

   int vectors = 0, fails = 0;
   int n_rise = 0, n_fall = 0, n_rst = 0, n_abort = 0;
   logic [7:0] shreg = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (sck_rise_en) begin
            n_rise = n_rise + 1;
            shreg  = {shreg[6:0], si_bit};
         end
         if (sck_fall_en) n_fall = n_fall + 1;
         if (eng_rst)     n_rst = n_rst + 1;
         if (abort_pulse) n_abort = n_abort + 1;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic sbit(input logic b);
      sck_pin = 1'b0; si_pin = b; tick(4);
      sck_pin = 1'b1; tick(4);
      sck_pin = 1'b0;
   endtask

   task automatic sbyte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) sbit(v[i]);
      tick(4);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      int n0, f0, r0, a0;
      rst_n = 0; cs_n_pin = 0; sck_pin = 0; si_pin = 0; hold_n_pin = 1;
      quad_en = 0; write_busy = 0; so_oe_req = 1; so_data = 1;
      tick(5); rst_n = 1; tick(6);
      check("R1 reset selected", selected, 0);
      check("R3 reset standby", standby, 1);
      check("R11 reset so_oe", so_oe, 0);

      // R1: chip-select low since reset gives nothing
      sbyte(8'h3C);
      check("R1 strobes with cs low from reset", n_rise, 0);
      check("R1 still unselected", selected, 0);
      cs_n_pin = 1; tick(6);
      check("R9 no eng_rst without prior select", n_rst, 0);
      cs_n_pin = 0; tick(6);
      check("R1 selected after high-low", selected, 1);
      check("R3 selected standby", standby, 0);
      check("R11 so_oe follows request", so_oe, 1);

      // R2: exhaustive byte sweep
      for (int v = 0; v < 256; v++) begin
         n0 = n_rise;
         sbyte(v[7:0]);
         check("R2 strobe count", n_rise - n0, 8);
         check("R2 captured byte", int'(shreg), v);
      end

      // R5/R6: pause splitting a byte
      sbit(1); sbit(0); sbit(0); sbit(1);
      tick(4);
      hold_n_pin = 0; tick(6);
      check("R5 hold entered", hold_active, 1);
      check("R5 so_oe off in hold", so_oe, 0);
      n0 = n_rise;
      sbit(1); sbit(1); sbit(0); tick(4);
      check("R5 no strobes in hold", n_rise - n0, 0);
      hold_n_pin = 1; tick(6);
      check("R5 hold left", hold_active, 0);
      check("R11 so_oe back", so_oe, 1);
      sbit(1); sbit(0); sbit(1); sbit(1); tick(4);
      check("R6 contiguous word", int'(shreg), 'h9B);

      // R7: pause pin changes while serial clock high
      sck_pin = 1; tick(6);
      hold_n_pin = 0; tick(6);
      check("R7 entry deferred", hold_active, 0);
      sck_pin = 0; tick(6);
      check("R7 entry after fall", hold_active, 1);
      sck_pin = 1; tick(6);
      hold_n_pin = 1; tick(6);
      check("R7 exit deferred", hold_active, 1);
      sck_pin = 0; tick(6);
      check("R7 exit after fall", hold_active, 0);

      // R8: deselect during pause
      hold_n_pin = 0; tick(6);
      check("R8 hold before deselect", hold_active, 1);
      r0 = n_rst; a0 = n_abort;
      cs_n_pin = 1; tick(6);
      check("R8 abort pulse", n_abort - a0, 1);
      check("R8 eng_rst pulse", n_rst - r0, 1);
      check("R8 hold cleared", hold_active, 0);
      check("R8 deselected", selected, 0);

      // R4: pause pin with chip-select high
      tick(6);
      check("R4 no hold while deselected", hold_active, 0);
      hold_n_pin = 1;

      // R3: standby versus write_busy
      write_busy = 1; tick(2);
      check("R3 busy blocks standby", standby, 0);
      write_busy = 0; tick(2);
      check("R3 standby idle", standby, 1);

      // R9: plain deselect
      cs_n_pin = 0; tick(6);
      check("R9 reselected", selected, 1);
      r0 = n_rst; a0 = n_abort;
      cs_n_pin = 1; tick(6);
      check("R9 eng_rst once", n_rst - r0, 1);
      check("R9 no abort", n_abort - a0, 0);
      cs_n_pin = 0; tick(6);

      // R10: quad mode ignores pause pin
      quad_en = 1; hold_n_pin = 0; tick(6);
      check("R10 no hold in quad", hold_active, 0);
      n0 = n_rise; f0 = n_fall;
      sbyte(8'h5A);
      check("R10 strobes continue", n_rise - n0, 8);
      check("R10 byte", int'(shreg), 'h5A);
      check("R11 fall strobes", n_fall - f0, 8);
      hold_n_pin = 1; quad_en = 0; tick(6);

      // R11: output enable follows request
      so_oe_req = 0; tick(2);
      check("R11 so_oe low on no request", so_oe, 0);
      so_oe_req = 1; tick(2);
      check("R11 so_oe high on request", so_oe, 1);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule